// File: doc/BRIEF.md
# CAN Nominal Bit Timing and Resynchronization Unit

This unit divides a selectable engine clock down to a time-quantum tick and walks every nominal CAN bit through four segments: a one-quantum sync segment, a propagation segment, phase segment 1 and phase segment 2. It produces a single-cycle strobe at the sample point and another when the sync quantum of a bit has elapsed. At the sample point it captures the received line value for the protocol layer above.

Recessive-to-dominant transitions on the received line keep the local bit clock aligned with the bus. When the bus is idle such a transition forces a hard synchronization. Otherwise it triggers a resynchronization that stretches phase segment 1 or trims phase segment 2, limited by a programmed jump width. All timing comes from one packed control word, which is captured only while the unit is disabled.

Both engine clocks arrive as clock-enable pulses in the `clk` domain. Every register in the unit runs on `clk`.

Top module: `can_bit_timing`

## Requirements
- R1: Control bit 19 selects the engine pulse source, where 0 selects `osc_en_i` and 1 selects `bus_en_i`. A quantum tick occurs on every (N+1)-th selected engine pulse, where N is the 8-bit prescaler in bits 7:0. A field of 0 gives a tick on every pulse. `tq_o` is high in the clock cycle after each tick.
- R2: With no synchronizing edge, a bit lasts 1 + (prop+1) + (ph1+1) + (ph2+1) quanta. The fields are prop in bits 12:10, ph1 in bits 15:13 and ph2 in bits 18:16. `bit_start_o` pulses after the tick that ends each sync quantum.
- R3: `sample_o` pulses after the tick that ends the last quantum of phase segment 1. In that same cycle `rx_bit_o` takes the `rx_i` value seen at that tick and holds it until the next sample. `sample_o` and `bit_start_o` are never high together.
- R4: A ph2 field of 0 is treated as 1, so phase segment 2 never lasts fewer than 2 quanta.
- R5: An edge is `rx_i` at 1 on the previous tick and 0 on this tick. An edge seen with `bus_idle_i` high is a hard synchronization. The current quantum is taken as the sync quantum, so `bit_start_o` pulses and the next quantum is the first propagation quantum. No resynchronization is then allowed before the next sample point.
- R6: A late edge is one seen in the propagation segment or phase segment 1, at quantum e counted from 1 after the sync quantum. It lengthens phase segment 1 by min(e, J) quanta, where J = jump field (bits 9:8) + 1.
- R7: An early edge is one seen in phase segment 2, with r quanta of the segment left including the current one. If r ≤ J, the current quantum becomes the sync quantum of the next bit. Otherwise phase segment 2 is shortened by J.
- R8: At most one resynchronization happens between two sample points. Later edges in that interval change nothing.
- R9: While `tx_dom_i` is high, edges cause neither hard synchronization nor resynchronization.
- R10: `cfg_i` is captured only while `enable_i` is low. While `enable_i` is low, the prescaler and the segment state are cleared and all strobes stay low.
- R11: Out of reset, `tq_o`, `sample_o` and `bit_start_o` are 0 and `rx_bit_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run enable; low clears state and opens configuration capture |
| osc_en_i | input | 1 | Oscillator engine pulse |
| bus_en_i | input | 1 | Bus-clock engine pulse |
| cfg_i | input | 20 | Packed timing control word |
| rx_i | input | 1 | Received bus line (1 recessive) |
| bus_idle_i | input | 1 | Bus idle / start-of-frame hint |
| tx_dom_i | input | 1 | Unit is transmitting a dominant bit |
| tq_o | output | 1 | Quantum tick strobe |
| sample_o | output | 1 | Sample-point strobe |
| rx_bit_o | output | 1 | Last sampled bit value |
| bit_start_o | output | 1 | End-of-sync strobe |

## Verification
The bench aims edges at every quantum of the bit: the sync quantum, every propagation and phase-1 position, and phase-2 positions on both sides of the jump-width threshold. This way, an off-by-one phase error or a misplaced boundary between trimming and restarting moves a strobe by one cycle. Edges that arrive after a resynchronization, during dominant transmission, or while the bus is idle expose a design that resynchronizes twice, listens to its own transmission, or skips hard synchronization. Phase segment 2 programmed as 0 and configuration writes made while running catch a block that produces a one-quantum phase 2 or changes its timing in the middle of a bit.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  parameter int PRESC_W = 8;
  parameter int SJW_W   = 2;
  parameter int SEG_W   = 3;
  localparam int CFG_W  = PRESC_W + SJW_W + 3 * SEG_W + 1;
  localparam int LEN_W  = SEG_W + 2;

  typedef struct packed {
    logic               clk_sel;
    logic [SEG_W-1:0]   ph2;
    logic [SEG_W-1:0]   ph1;
    logic [SEG_W-1:0]   prop;
    logic [SJW_W-1:0]   jump;
    logic [PRESC_W-1:0] presc;
  } bt_cfg_t;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } bt_seg_e;
endpackage

// File: rtl/can_bt_rst_sync.sv
module can_bt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [CFG_W-1:0] cfg_i,
  output bt_cfg_t          cfg_o
);
  bt_cfg_t cfg_q, cfg_n;

  always_comb begin
    cfg_n = cfg_q;
    if (!enable_i) cfg_n = bt_cfg_t'(cfg_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_n;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler
  import can_bt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic               osc_en_i,
  input  logic               bus_en_i,
  input  logic               sel_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q, cnt_n;
  logic               eng;

  always_comb begin
    eng    = sel_i ? bus_en_i : osc_en_i;
    tick_o = enable_i && eng && (cnt_q == presc_i);
    cnt_n  = cnt_q;
    if (!enable_i)   cnt_n = '0;
    else if (tick_o) cnt_n = '0;
    else if (eng)    cnt_n = cnt_q + PRESC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic             rx_i,
  input  logic             bus_idle_i,
  input  logic             tx_dom_i,
  input  logic [LEN_W-1:0] prop_len_i,
  input  logic [LEN_W-1:0] ph1_len_i,
  input  logic [LEN_W-1:0] ph2_len_i,
  input  logic [LEN_W-1:0] jump_len_i,
  output logic             tq_o,
  output logic             sample_o,
  output logic             bit_start_o,
  output logic             rx_bit_o
);
  localparam logic [LEN_W-1:0] L1 = LEN_W'(1);

  bt_seg_e          seg_q, seg_n;
  logic [LEN_W-1:0] cnt_q, cnt_n, ph1_q, ph1_n, ph2_q, ph2_n;
  logic             rs_q, rs_n, rxl_q, rxl_n, rxb_q, rxb_n;
  logic             tq_q, tq_n, smp_q, smp_n, bst_q, bst_n;
  logic             edge_c, restart;
  logic [LEN_W-1:0] late_err, early_rem, len1, len2;

  function automatic logic [LEN_W-1:0] jump_clamp(input logic [LEN_W-1:0] err,
                                                  input logic [LEN_W-1:0] lim);
    return (err > lim) ? lim : err;
  endfunction

  assign edge_c    = rxl_q && !rx_i && !tx_dom_i;
  assign late_err  = (seg_q == SEG_PH1) ? (prop_len_i + cnt_q + L1) : (cnt_q + L1);
  assign early_rem = ph2_q - cnt_q;

  always_comb begin
    seg_n   = seg_q;
    cnt_n   = cnt_q;
    ph1_n   = ph1_q;
    ph2_n   = ph2_q;
    rs_n    = rs_q;
    rxl_n   = rxl_q;
    rxb_n   = rxb_q;
    tq_n    = 1'b0;
    smp_n   = 1'b0;
    bst_n   = 1'b0;
    restart = 1'b0;
    len1    = ph1_q;
    len2    = ph2_q;
    if (tick_i) begin
      tq_n  = 1'b1;
      rxl_n = rx_i;
      if (edge_c && bus_idle_i) begin
        restart = 1'b1;
        rs_n    = 1'b1;
      end else begin
        unique case (seg_q)
          SEG_SYNC: restart = 1'b1;
          SEG_PROP, SEG_PH1: begin
            if (edge_c && !rs_q) begin
              len1  = ph1_len_i + jump_clamp(late_err, jump_len_i);
              ph1_n = len1;
              rs_n  = 1'b1;
            end
            if (seg_q == SEG_PROP) begin
              if (cnt_q == prop_len_i - L1) begin
                seg_n = SEG_PH1;
                cnt_n = '0;
              end else begin
                cnt_n = cnt_q + L1;
              end
            end else if (cnt_q == len1 - L1) begin
              smp_n = 1'b1;
              rxb_n = rx_i;
              rs_n  = 1'b0;
              seg_n = SEG_PH2;
              cnt_n = '0;
            end else begin
              cnt_n = cnt_q + L1;
            end
          end
          SEG_PH2: begin
            if (edge_c && !rs_q) begin
              rs_n = 1'b1;
              if (early_rem <= jump_len_i) begin
                restart = 1'b1;
              end else begin
                len2  = ph2_q - jump_len_i;
                ph2_n = len2;
              end
            end
            if (!restart) begin
              if (cnt_q == len2 - L1) begin
                seg_n = SEG_SYNC;
                cnt_n = '0;
              end else begin
                cnt_n = cnt_q + L1;
              end
            end
          end
          default: restart = 1'b1;
        endcase
      end
      if (restart) begin
        seg_n = SEG_PROP;
        cnt_n = '0;
        ph1_n = ph1_len_i;
        ph2_n = ph2_len_i;
        bst_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_SYNC;
      cnt_q <= '0;
      ph1_q <= '0;
      ph2_q <= '0;
      rs_q  <= 1'b0;
      rxl_q <= 1'b1;
      rxb_q <= 1'b1;
      tq_q  <= 1'b0;
      smp_q <= 1'b0;
      bst_q <= 1'b0;
    end else if (!enable_i) begin
      seg_q <= SEG_SYNC;
      cnt_q <= '0;
      ph1_q <= '0;
      ph2_q <= '0;
      rs_q  <= 1'b0;
      rxl_q <= 1'b1;
      rxb_q <= 1'b1;
      tq_q  <= 1'b0;
      smp_q <= 1'b0;
      bst_q <= 1'b0;
    end else begin
      seg_q <= seg_n;
      cnt_q <= cnt_n;
      ph1_q <= ph1_n;
      ph2_q <= ph2_n;
      rs_q  <= rs_n;
      rxl_q <= rxl_n;
      rxb_q <= rxb_n;
      tq_q  <= tq_n;
      smp_q <= smp_n;
      bst_q <= bst_n;
    end
  end

  assign tq_o        = tq_q;
  assign sample_o    = smp_q;
  assign bit_start_o = bst_q;
  assign rx_bit_o    = rxb_q;
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             osc_en_i,
  input  logic             bus_en_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             rx_i,
  input  logic             bus_idle_i,
  input  logic             tx_dom_i,
  output logic             tq_o,
  output logic             sample_o,
  output logic             rx_bit_o,
  output logic             bit_start_o
);
  localparam logic [LEN_W-1:0] L1 = LEN_W'(1);

  logic             rst_int_n, tick;
  bt_cfg_t          cfg_q;
  logic [SEG_W-1:0] ph2_eff;
  logic [LEN_W-1:0] prop_len, ph1_len, ph2_len, jump_len;

  can_bt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  can_bt_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .enable_i (enable_i),
    .cfg_i    (cfg_i),
    .cfg_o    (cfg_q)
  );

  always_comb begin
    ph2_eff  = (cfg_q.ph2 == '0) ? SEG_W'(1) : cfg_q.ph2;
    prop_len = LEN_W'(cfg_q.prop) + L1;
    ph1_len  = LEN_W'(cfg_q.ph1) + L1;
    ph2_len  = LEN_W'(ph2_eff) + L1;
    jump_len = LEN_W'(cfg_q.jump) + L1;
  end

  can_bt_prescaler u_presc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .enable_i (enable_i),
    .osc_en_i (osc_en_i),
    .bus_en_i (bus_en_i),
    .sel_i    (cfg_q.clk_sel),
    .presc_i  (cfg_q.presc),
    .tick_o   (tick)
  );

  can_bt_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .enable_i    (enable_i),
    .tick_i      (tick),
    .rx_i        (rx_i),
    .bus_idle_i  (bus_idle_i),
    .tx_dom_i    (tx_dom_i),
    .prop_len_i  (prop_len),
    .ph1_len_i   (ph1_len),
    .ph2_len_i   (ph2_len),
    .jump_len_i  (jump_len),
    .tq_o        (tq_o),
    .sample_o    (sample_o),
    .bit_start_o (bit_start_o),
    .rx_bit_o    (rx_bit_o)
  );
endmodule

// File: rtl/can_bt_checker.sv
module can_bt_checker (
  input logic clk,
  input logic rst_n,
  input logic enable_i,
  input logic osc_en_i,
  input logic bus_en_i,
  input logic tq_o,
  input logic sample_o,
  input logic rx_bit_o,
  input logic bit_start_o
);
  AST_TQ_NEEDS_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    tq_o |-> $past(osc_en_i || bus_en_i)); // R1

  AST_START_ON_TQ: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start_o |-> tq_o); // R2

  AST_SAMPLE_ON_TQ: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> tq_o); // R3

  AST_SAMPLE_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_o && bit_start_o)); // R3

  AST_RXBIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && $past(enable_i) && !sample_o) |-> $stable(rx_bit_o)); // R3

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!tq_o && !sample_o && !bit_start_o)); // R10
endmodule

bind can_bit_timing can_bt_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable_i    (enable_i),
  .osc_en_i    (osc_en_i),
  .bus_en_i    (bus_en_i),
  .tq_o        (tq_o),
  .sample_o    (sample_o),
  .rx_bit_o    (rx_bit_o),
  .bit_start_o (bit_start_o)
);

// File: tb/tb_can_bit_timing.sv
module tb_can_bit_timing;
  import can_bt_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, enable;
  logic [CFG_W-1:0] cfg;
  logic             osc_en, bus_en, rx, idle, txd;
  logic             tq_o, sample_o, rx_bit_o, bit_start_o;

  logic [15:0] lfsr = 16'hACE1;
  int          cyc = 0;
  logic        rnd_rx = 1'b1;
  bit          osc_full = 1, bus_half = 0, rx_rand = 0, idle_rand = 0, txd_rand = 0;
  logic        rx_hold = 1'b1, idle_hold = 1'b0, txd_hold = 1'b0;

  assign osc_en = osc_full ? 1'b1 : lfsr[3];
  assign bus_en = bus_half ? cyc[0] : lfsr[7];
  assign rx     = rx_rand ? rnd_rx : rx_hold;
  assign idle   = idle_rand ? (lfsr[5] & lfsr[9]) : idle_hold;
  assign txd    = txd_rand ? lfsr[11] : txd_hold;

  always @(negedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (lfsr[2:0] == 3'd0) rnd_rx <= ~rnd_rx;
  end

  can_bit_timing dut (
    .clk (clk), .rst_n (rst_n), .enable_i (enable), .osc_en_i (osc_en),
    .bus_en_i (bus_en), .cfg_i (cfg), .rx_i (rx), .bus_idle_i (idle),
    .tx_dom_i (txd), .tq_o (tq_o), .sample_o (sample_o),
    .rx_bit_o (rx_bit_o), .bit_start_o (bit_start_o)
  );

  int    n_checks = 0, n_err = 0;
  bit    chk_on = 0, done = 0;
  string cur_req = "R11";

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic logic [CFG_W-1:0] mk_cfg(input int sel, input int ph2, input int ph1,
                                               input int prop, input int jump, input int presc);
    return {sel[0], ph2[2:0], ph1[2:0], prop[2:0], jump[1:0], presc[7:0]};
  endfunction

  // Behavioural reference: position in quanta since start of bit.
  logic [CFG_W-1:0] m_cfg;
  int  m_pc, m_pos, m_t1x, m_t2x, mP, mT1, mT2, mJ, mPR, mC, mRem;
  bit  m_rs, m_rxl, m_rxb, e_tq, e_smp, e_bst, m_tick, m_eng, m_edge, m_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = '0; m_pc = 0; m_pos = 0; m_t1x = 0; m_t2x = 0;
      m_rs = 0; m_rxl = 1; m_rxb = 1; e_tq = 0; e_smp = 0; e_bst = 0;
    end else if (!enable) begin
      m_cfg = cfg; m_pc = 0; m_pos = 0; m_rs = 0; m_rxl = 1; m_rxb = 1;
      e_tq = 0; e_smp = 0; e_bst = 0;
    end else begin
      mPR    = int'(m_cfg[7:0]);
      mJ     = int'(m_cfg[9:8]) + 1;
      mP     = int'(m_cfg[12:10]) + 1;
      mT1    = int'(m_cfg[15:13]) + 1;
      mT2    = ((m_cfg[18:16] == 3'd0) ? 1 : int'(m_cfg[18:16])) + 1;
      m_eng  = m_cfg[19] ? bus_en : osc_en;
      m_tick = m_eng && (m_pc == mPR);
      if (m_eng) m_pc = m_tick ? 0 : m_pc + 1;
      e_tq = m_tick; e_smp = 0; e_bst = 0;
      if (m_tick) begin
        m_edge = m_rxl && !rx && !txd;
        m_rst  = 0;
        if (m_edge && idle) begin
          m_rst = 1; m_rs = 1;
        end else if (m_pos == 0) begin
          m_rst = 1;
        end else if (m_pos <= mP + m_t1x) begin
          if (m_edge && !m_rs) begin
            m_t1x = mT1 + ((m_pos < mJ) ? m_pos : mJ);
            m_rs  = 1;
          end
          if (m_pos == mP + m_t1x) begin
            e_smp = 1; m_rxb = rx; m_rs = 0;
          end
          m_pos++;
        end else begin
          mC   = m_pos - (1 + mP + m_t1x);
          mRem = m_t2x - mC;
          if (m_edge && !m_rs) begin
            m_rs = 1;
            if (mRem <= mJ) m_rst = 1;
            else m_t2x = m_t2x - mJ;
          end
          if (!m_rst) m_pos = (m_pos == mP + m_t1x + m_t2x) ? 0 : m_pos + 1;
        end
        if (m_rst) begin
          m_pos = 1; m_t1x = mT1; m_t2x = mT2; e_bst = 1;
        end
        m_rxl = rx;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      check(tq_o === e_tq, cur_req, "tq_o", int'(tq_o), int'(e_tq));
      check(sample_o === e_smp, cur_req, "sample_o", int'(sample_o), int'(e_smp));
      check(bit_start_o === e_bst, cur_req, "bit_start_o", int'(bit_start_o), int'(e_bst));
      check(rx_bit_o === m_rxb, cur_req, "rx_bit_o", int'(rx_bit_o), int'(m_rxb));
    end
  end

  task automatic setup(input logic [CFG_W-1:0] v);
    @(negedge clk);
    enable = 1'b0;
    cfg    = v;
    repeat (3) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic wait_start();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (bit_start_o) break;
    end
  endtask

  task automatic period(output int n);
    wait_start();
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bit_start_o && n < 3000);
  endtask

  task automatic sample_offset(output int n);
    wait_start();
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sample_o && n < 3000);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; enable = 1'b0; cfg = '0;
    repeat (3) @(negedge clk);
    check(tq_o == 0 && sample_o == 0 && bit_start_o == 0, "R11", "strobes at reset",
          int'({tq_o, sample_o, bit_start_o}), 0);
    check(rx_bit_o == 1, "R11", "rx_bit_o at reset", int'(rx_bit_o), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1;

    // R1: prescaler 3 on oscillator pulses, then prescaler 1 on bus pulses
    cur_req = "R1";
    setup(mk_cfg(0, 3, 2, 1, 1, 3));
    n = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); if (tq_o) n++; end
    check(n == 20, "R1", "tq count osc presc 3", n, 20);
    bus_half = 1;
    setup(mk_cfg(1, 3, 2, 1, 1, 1));
    n = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); if (tq_o) n++; end
    check(n == 20, "R1", "tq count bus presc 1", n, 20);
    bus_half = 0;

    // R2 and R3: nominal bit with no edges
    cur_req = "R2";
    setup(mk_cfg(0, 3, 2, 1, 1, 0));
    period(n);
    check(n == 10, "R2", "bit period quanta", n, 10);
    cur_req = "R3";
    sample_offset(n);
    check(n == 5, "R3", "sample offset after start", n, 5);

    // R4: phase 2 field of zero acts as one
    cur_req = "R4";
    setup(mk_cfg(0, 0, 2, 1, 1, 0));
    period(n);
    check(n == 8, "R4", "bit period with ph2 field 0", n, 8);

    // R10: configuration written while running is not taken
    cur_req = "R10";
    @(negedge clk);
    cfg = mk_cfg(0, 6, 5, 4, 2, 0);
    period(n);
    check(n == 8, "R10", "period after write while enabled", n, 8);
    enable = 1'b0;
    @(negedge clk);
    check(tq_o == 0 && bit_start_o == 0, "R10", "strobes after disable",
          int'({tq_o, bit_start_o}), 0);

    // R5: directed hard synchronization at the first propagation quantum
    cur_req = "R5";
    idle_hold = 1'b1;
    setup(mk_cfg(0, 3, 2, 1, 1, 0));
    wait_start();
    rx_hold = 1'b0;
    @(negedge clk);
    check(bit_start_o == 1, "R5", "bit_start after idle edge", int'(bit_start_o), 1);
    rx_hold = 1'b1;
    repeat (12) @(negedge clk);

    // R9: same edge while transmitting dominant is ignored
    cur_req = "R9";
    txd_hold = 1'b1;
    wait_start();
    rx_hold = 1'b0;
    @(negedge clk);
    check(bit_start_o == 0, "R9", "bit_start after edge during tx", int'(bit_start_o), 0);
    rx_hold = 1'b1; txd_hold = 1'b0; idle_hold = 1'b0;
    repeat (12) @(negedge clk);

    // R6 R7 R8: random edges against the reference, several timings
    cur_req = "R6 R7 R8";
    rx_rand = 1;
    setup(mk_cfg(0, 3, 2, 1, 0, 0)); repeat (4000) @(negedge clk);
    setup(mk_cfg(0, 7, 7, 7, 3, 0)); repeat (4000) @(negedge clk);
    setup(mk_cfg(0, 1, 0, 0, 1, 1)); repeat (4000) @(negedge clk);
    setup(mk_cfg(0, 5, 3, 2, 2, 0)); repeat (4000) @(negedge clk);
    osc_full = 0;
    setup(mk_cfg(1, 2, 4, 2, 2, 0)); repeat (4000) @(negedge clk);
    osc_full = 1;

    cur_req = "R5";
    idle_rand = 1;
    setup(mk_cfg(0, 4, 3, 1, 1, 0)); repeat (4000) @(negedge clk);
    setup(mk_cfg(0, 6, 1, 3, 3, 0)); repeat (4000) @(negedge clk);

    cur_req = "R9";
    txd_rand = 1;
    setup(mk_cfg(0, 4, 3, 1, 1, 0)); repeat (4000) @(negedge clk);
    setup(mk_cfg(0, 2, 6, 0, 2, 1)); repeat (4000) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule